// File: doc/BRIEF.md
# Timer Capture Queue with Overflow Lockout

This block holds timer values captured on external events until software collects them. Each capture strobe presents a 16-bit timestamp. Up to four timestamps are kept and returned oldest first through a single read strobe. The read value is registered and appears on the cycle after the read. A status output shows whether any timestamp is waiting.

When a capture arrives and all four slots are still unread, that capture is thrown away and an overflow flag is raised. From then on every capture is refused until software has drained all four held values. The queue never overwrites old data.

An interrupt pulse lasting one cycle is raised after a programmable number of accepted captures, from one to four. A separate input forces a pulse on every accepted capture, as needed when both edges of the input are captured. A module-off input empties the queue and clears the overflow flag and the capture counter.

Top module: `capture_queue`

## Requirements
- R1: Accepted captures are returned in arrival order. `rd_data` takes the oldest held value on the clock edge at which `rd_stb` is sampled with at least one entry held, and keeps that value until the next such read.
- R2: `not_empty` is 1 exactly when at least one entry is held. It changes on the same edge that stores the first entry or removes the last one. At most four entries are held.
- R3: A capture sampled while four unread entries are held is not stored, sets `overflow` on that edge and produces no `irq`.
- R4: While `overflow` is 1, every capture is dropped. It stores nothing, does not advance the interrupt count and produces no `irq`.
- R5: `overflow` clears on the edge at which the read removing the last held entry is taken. While any entry is still held, it stays set.
- R6: `mod_off` sampled high empties the queue, clears `overflow`, `irq` and the capture counter, and drops any capture or read in that cycle. `rd_data` is unchanged.
- R7: With `irq_each` = 0 and `irq_sel` = N (0 to 3), `irq` is 1 for one cycle, the cycle after every (N+1)-th accepted capture. The counter restarts after each pulse.
- R8: With `irq_each` = 1, every accepted capture gives an `irq` pulse the following cycle, whatever the value of `irq_sel`.
- R9: A read while empty leaves `rd_data`, `not_empty` and `overflow` unchanged.
- R10: When fewer than four entries are held, a capture and a read in the same cycle are both performed. The oldest value is read out, the new one is stored, and the entry count is unchanged.
- R11: After reset, `rd_data` is 0 and `not_empty`, `overflow` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_stb | input | 1 | Capture strobe, one sample per cycle |
| cap_data | input | 16 | Timer value to store |
| rd_stb | input | 1 | Read strobe, takes the oldest entry |
| mod_off | input | 1 | Module-off clear |
| irq_sel | input | 2 | Captures per interrupt minus one |
| irq_each | input | 1 | Interrupt on every capture, `irq_sel` ignored |
| rd_data | output | 16 | Registered read value |
| not_empty | output | 1 | At least one entry held |
| overflow | output | 1 | Capture lost, lockout active |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that the strobes are sampled as single-cycle events. They also assume that `irq_sel` and `irq_each` are held steady around a capture, because the interrupt check reads them on the capture edge. The stimulus changes inputs only at the falling clock edge. It changes the interrupt settings only between scenario steps, never in a cycle that carries a capture. It drives the queue to full, into lockout and through module-off clears, so the overflow properties are exercised and not only vacuously true.

// File: rtl/capq_pkg.sv
package capq_pkg;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_DEPTH  = 4;
  localparam int unsigned DEF_SEL_W  = 2;

  // Per-cycle decisions made at the top and fanned out to the sub-blocks.
  typedef struct packed {
    logic push;      // capture accepted into storage
    logic pop;       // read taken from storage
    logic full_hit;  // capture arrived with every slot occupied
    logic drain;     // read removes the final held entry
  } capq_ctl_t;
endpackage

// File: rtl/capq_rst_sync.sv
module capq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/capq_store.sv
module capq_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH-1);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  // Storage: one enabled register per slot, no reset on data.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = push && !clr && (wr_ptr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[i] <= wdata;
    end
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    rdata_d  = rdata_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push) wr_ptr_d = (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + 1'b1;
      if (pop) begin
        rd_ptr_d = (rd_ptr_q == LAST_SLOT) ? '0 : rd_ptr_q + 1'b1;
        rdata_d  = slot_q[rd_ptr_q];
      end
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      rdata_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign count = cnt_q;

  // R2: occupancy never exceeds the depth.
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R3: a full store is never written.
  assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(DEPTH)) |-> !push);

  // R9: an empty store is never read.
  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !pop);
endmodule

// File: rtl/capq_ovf.sv
module capq_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic full_hit,
  input  logic drain,
  output logic overflow
);
  logic ovf_q, ovf_d;

  always_comb begin
    ovf_d = ovf_q;
    if (clr)           ovf_d = 1'b0;
    else if (full_hit) ovf_d = 1'b1;
    else if (drain)    ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign overflow = ovf_q;

  // R3: a capture into a full queue raises the lockout.
  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_hit && !clr) |=> ovf_q);
endmodule

// File: rtl/capq_irq.sv
module capq_irq #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [SEL_W-1:0] sel,
  input  logic             each,
  output logic             irq
);
  logic [SEL_W-1:0] grp_q, grp_d;
  logic             irq_q, irq_d;

  always_comb begin
    grp_d = grp_q;
    irq_d = 1'b0;
    if (clr) begin
      grp_d = '0;
    end else if (push) begin
      if (each) begin
        irq_d = 1'b1;
        grp_d = '0;
      end else if (grp_q == sel) begin
        irq_d = 1'b1;
        grp_d = '0;
      end else begin
        grp_d = grp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
      irq_q <= 1'b0;
    end else begin
      grp_q <= grp_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  // R8: forced mode pulses on every accepted capture.
  assert_each_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && each && !clr) |=> irq_q);

  // R7: a pulse always follows an accepted capture.
  assert_irq_after_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(push && !clr));
endmodule

// File: rtl/capture_queue.sv
module capture_queue
  import capq_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned SEL_W  = DEF_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_stb,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              rd_stb,
  input  logic              mod_off,
  input  logic [SEL_W-1:0]  irq_sel,
  input  logic              irq_each,
  output logic [DATA_W-1:0] rd_data,
  output logic              not_empty,
  output logic              overflow,
  output logic              irq
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic             rst_n_sync;
  logic [CNT_W-1:0] count;
  logic             full;
  capq_ctl_t        ctl;

  capq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign full = (count == CNT_W'(DEPTH));

  always_comb begin
    ctl.push     = cap_stb && !mod_off && !overflow && !full;
    ctl.pop      = rd_stb  && !mod_off && not_empty;
    ctl.full_hit = cap_stb && !mod_off && !overflow && full;
    ctl.drain    = ctl.pop && !ctl.push && (count == CNT_W'(1));
  end

  capq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (mod_off),
    .push  (ctl.push),
    .pop   (ctl.pop),
    .wdata (cap_data),
    .rdata (rd_data),
    .count (count)
  );

  capq_ovf u_ovf (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .clr      (mod_off),
    .full_hit (ctl.full_hit),
    .drain    (ctl.drain),
    .overflow (overflow)
  );

  capq_irq #(.SEL_W(SEL_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (mod_off),
    .push  (ctl.push),
    .sel   (irq_sel),
    .each  (irq_each),
    .irq   (irq)
  );

  assign not_empty = (count != '0);

  // R3: a refused capture into a full queue raises no interrupt.
  assert_ovf_no_irq_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cap_stb && full && !mod_off) |=> !irq);

  // R4: during lockout captures leave occupancy untouched unless read.
  assert_hold_while_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (overflow && cap_stb && !rd_stb && !mod_off) |=> ($stable(count) && !irq));

  // R5: lockout only rises from a full queue.
  assert_ovf_from_full_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(overflow) |-> $past(full));

  // R6: module-off empties the queue and drops the lockout.
  assert_off_clear_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mod_off |=> (!not_empty && !overflow && !irq));

  // R9: reading an empty queue keeps the read value.
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_stb && !not_empty) |=> $stable(rd_data));
endmodule

// File: tb/capture_queue_test.sv
`timescale 1ns/1ps
module capture_queue_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cap_stb, rd_stb, mod_off, irq_each;
  logic [15:0] cap_data;
  logic [1:0]  irq_sel;
  logic [15:0] rd_data;
  logic        not_empty, overflow, irq;

  int errors = 0;
  int checks = 0;

  // Reference state built from the requirements.
  logic [15:0] mq[$];
  logic        m_ovf;
  logic [1:0]  m_grp;
  logic [15:0] m_rd;
  logic        m_irq;

  always #2.5 clk = ~clk;

  capture_queue uut (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .cap_data(cap_data),
    .rd_stb(rd_stb), .mod_off(mod_off), .irq_sel(irq_sel), .irq_each(irq_each),
    .rd_data(rd_data), .not_empty(not_empty), .overflow(overflow), .irq(irq)
  );

  task automatic compare(input string tag);
    checks++;
    if (rd_data !== m_rd || not_empty !== (mq.size() != 0) ||
        overflow !== m_ovf || irq !== m_irq) begin
      errors++;
      $display("FAIL %s: rd=%h/%h ne=%b/%b ov=%b/%b irq=%b/%b (actual/expected)",
               tag, rd_data, m_rd, not_empty, (mq.size() != 0),
               overflow, m_ovf, irq, m_irq);
    end
  endtask

  // One clock cycle of stimulus, reference update and check.
  task automatic step(input logic cap, input logic [15:0] d, input logic rd,
                      input logic off, input string tag);
    bit full, pop, push;
    @(negedge clk);
    cap_stb = cap; cap_data = d; rd_stb = rd; mod_off = off;
    m_irq = 1'b0;
    if (off) begin
      mq.delete(); m_ovf = 1'b0; m_grp = '0;
    end else begin
      full = (mq.size() == 4);
      pop  = rd && (mq.size() != 0);
      push = cap && !m_ovf && !full;
      if (cap && !m_ovf && full) m_ovf = 1'b1;
      else if (pop && !push && m_ovf && mq.size() == 1) m_ovf = 1'b0;
      if (pop) m_rd = mq.pop_front();
      if (push) begin
        mq.push_back(d);
        if (irq_each || m_grp == irq_sel) begin
          m_irq = 1'b1; m_grp = '0;
        end else m_grp = m_grp + 1'b1;
      end
    end
    @(posedge clk);
    #1;
    cap_stb = 1'b0; rd_stb = 1'b0; mod_off = 1'b0;
    compare(tag);
  endtask

  task automatic t_reset();
    compare("R11 reset state");
  endtask

  task automatic t_order();
    irq_sel = 2'd3; irq_each = 1'b0;
    step(1, 16'h1111, 0, 0, "R2 first capture sets not_empty");
    step(1, 16'h2222, 0, 0, "R1 second capture");
    step(1, 16'h3333, 0, 0, "R1 third capture");
    step(0, 16'h0, 1, 0, "R1 oldest read");
    step(0, 16'h0, 0, 0, "R1 read value held");
    step(0, 16'h0, 1, 0, "R1 second read");
    step(0, 16'h0, 1, 0, "R2 last read clears not_empty");
  endtask

  task automatic t_empty_read();
    step(0, 16'h0, 1, 0, "R9 read while empty");
    step(0, 16'h0, 1, 0, "R9 repeated empty read");
  endtask

  task automatic t_overflow();
    irq_sel = 2'd0; irq_each = 1'b0;
    for (int i = 0; i < 4; i++) step(1, 16'hA000 + 16'(i), 0, 0, "R7 fill with sel 0");
    step(1, 16'hBAD0, 0, 0, "R3 fifth capture dropped, overflow set, no irq");
    step(1, 16'hBAD1, 0, 0, "R4 capture during lockout dropped");
    step(0, 16'h0, 1, 0, "R5 read one, lockout stays");
    step(1, 16'hBAD2, 0, 0, "R4 capture with free slot still dropped");
    step(0, 16'h0, 1, 0, "R5 read two");
    step(0, 16'h0, 1, 0, "R5 read three");
    step(0, 16'h0, 1, 0, "R5 read four clears overflow");
    step(1, 16'hC001, 0, 0, "R5 capture accepted after drain");
    step(0, 16'h0, 1, 0, "R1 post-drain value");
  endtask

  task automatic t_full_rw();
    irq_sel = 2'd3; irq_each = 1'b0;
    for (int i = 0; i < 4; i++) step(1, 16'hD000 + 16'(i), 0, 0, "R7 fill with sel 3");
    step(1, 16'hDEAD, 1, 0, "R3 capture into full with read: dropped, read taken");
    for (int i = 0; i < 3; i++) step(0, 16'h0, 1, 0, "R5 drain after full read");
  endtask

  task automatic t_simul();
    irq_sel = 2'd1; irq_each = 1'b0;
    step(1, 16'h5001, 0, 0, "R7 first of pair");
    step(1, 16'h5002, 1, 0, "R10 capture and read together");
    step(1, 16'h5003, 1, 0, "R10 capture and read together again");
    step(0, 16'h0, 1, 0, "R10 remaining entry");
    step(1, 16'h5004, 1, 0, "R10 read on empty with capture stores only");
    step(0, 16'h0, 1, 0, "R1 read back stored entry");
  endtask

  task automatic t_groups();
    irq_sel = 2'd2; irq_each = 1'b0;
    for (int i = 0; i < 6; i++) step(1, 16'h6000 + 16'(i), (i > 1), 0, "R7 groups of three");
    for (int i = 0; i < 3; i++) step(0, 16'h0, 1, 0, "R7 drain");
  endtask

  task automatic t_each();
    irq_sel = 2'd3; irq_each = 1'b1;
    for (int i = 0; i < 3; i++) step(1, 16'h7000 + 16'(i), 0, 0, "R8 pulse per capture");
    for (int i = 0; i < 3; i++) step(0, 16'h0, 1, 0, "R8 drain");
    irq_each = 1'b0;
  endtask

  task automatic t_off();
    irq_sel = 2'd3; irq_each = 1'b0;
    for (int i = 0; i < 4; i++) step(1, 16'h8000 + 16'(i), 0, 0, "R6 fill before off");
    step(1, 16'h8BAD, 0, 0, "R6 lockout before off");
    step(1, 16'h8F00, 1, 1, "R6 module off clears all, rd_data kept");
    step(0, 16'h0, 1, 0, "R6 empty after off");
    irq_sel = 2'd1;
    step(1, 16'h8101, 0, 0, "R6 counter restarted, no irq yet");
    step(1, 16'h8102, 0, 0, "R6 irq on second capture after off");
    step(1, 16'h8103, 0, 0, "R6 partial group before off");
    step(0, 16'h0, 0, 1, "R6 off drops partial group");
    step(1, 16'h8104, 0, 0, "R6 fresh count after off");
    step(0, 16'h0, 1, 0, "R1 read after off");
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cap_stb = 1'b0; rd_stb = 1'b0; mod_off = 1'b0;
    cap_data = '0; irq_sel = '0; irq_each = 1'b0;
    m_ovf = 1'b0; m_grp = '0; m_rd = '0; m_irq = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_order();
    t_empty_read();
    t_overflow();
    t_full_rw();
    t_simul();
    t_groups();
    t_each();
    t_off();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule